// File: doc/BRIEF.md
# SIMD Widening Multiply-Accumulate Unit

This block is a lane-parallel multiply-accumulate datapath for 256-bit vector registers. Each request carries three vectors and a small control word. The vectors are an accumulator and two sources. The control word selects the operation, the element size and the signedness mode. The unit returns the updated accumulator vector.

Two kinds of operation are supported. Same-width multiply-add and multiply-subtract work on 8, 16, 32 or 64-bit lanes. Widening accumulate picks either the even or the odd narrow elements of both sources. It multiplies each pair to a full-width product and adds that product into a lane twice as wide, up to 128-bit lanes.

The unit has one request handshake (in_valid/in_ready) and one registered result stage (out_valid/out_ready). It is built around a two-state stage controller:

- EMPTY: no result is held.
- FULL: a result is presented.

It moves between them through three transitions:

- LOAD (EMPTY to FULL): a request is accepted.
- DRAIN (FULL to EMPTY): the result is taken and no new request is accepted.
- REFILL (FULL to FULL): the result is taken and a new request is accepted in the same cycle.

A request whose control combination is not supported is still accepted. It returns the accumulator unchanged and raises the illegal flag.

Top module: `vmac_unit`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: op = 0 (multiply-add) with elem_size 0/1/2/3 splits the vectors into 8/16/32/64-bit lanes. Each lane becomes acc + a*b, keeping only the low lane-width bits.
- R3: op = 1 (multiply-subtract) gives acc - a*b per lane, with the same lane widths and wraparound as R2.
- R4: op = 2 (widening even) with elem_size 0/1/2/3 uses destination lanes of 16/32/64/128 bits. Destination lane i adds the full product of narrow element 2i of src_a and narrow element 2i of src_b.
- R5: op = 3 (widening odd) behaves as R4 but uses narrow element 2i+1 of each source.
- R6: For 128-bit accumulator lanes, a carry out of bit 63 of the low word enters the high word. Each 128-bit half of the vector is computed independently of the other.
- R7: sign_mode selects how narrow operands are extended before multiplying:
  - 0: both sources are sign-extended.
  - 1: both sources are zero-extended.
  - 2: src_a is zero-extended and src_b is sign-extended.
- R8: The following combinations are illegal:
  - sign_mode 3, with any op.
  - sign_mode 2 with op 0 or 1.

  An illegal request returns result equal to acc_in with illegal = 1. Legal requests return illegal = 0.
- R9: A request accepted at a clock edge (in_valid and in_ready both 1) is presented with out_valid = 1 from that edge on.
- R10: While out_valid is 1 and out_ready is 0, result and illegal stay stable and in_ready is 0. Otherwise in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| op | input | 2 | 0 multiply-add, 1 multiply-subtract, 2 widening even, 3 widening odd |
| elem_size | input | 2 | Element size code; for widening ops it gives the destination lane size |
| sign_mode | input | 2 | 0 signed, 1 unsigned, 2 unsigned-by-signed, 3 reserved |
| acc_in | input | 256 | Accumulator vector |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 256 | Updated accumulator vector |
| illegal | output | 1 | Request combination was unsupported |

## Verification
The hardest case to reach from the ports is the carry from the low 64-bit word into the high word of a 128-bit accumulator lane. Random operands almost never make the low word overflow while the other half of the vector is left undisturbed. The stimulus therefore sets the low word of one 128-bit accumulator to all ones and multiplies small selected elements. The other 128-bit half gets a zero accumulator, so any leakage between halves would show. Backpressure with a held result, and same-cycle take-and-refill, come from random out_ready patterns in a streaming phase. In that phase a cycle model predicts every handshake.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

    typedef enum logic [1:0] {
        OP_MADD  = 2'd0,
        OP_MSUB  = 2'd1,
        OP_WEVEN = 2'd2,
        OP_WODD  = 2'd3
    } mac_op_e;

    typedef enum logic [1:0] {
        SM_SS  = 2'd0,
        SM_UU  = 2'd1,
        SM_US  = 2'd2,
        SM_BAD = 2'd3
    } sign_mode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_e;

    // Number of lane-width groups: 8, 16, 32, 64 and 128 bits.
    localparam int NUM_GRP = 5;
    localparam int GRP_W   = $clog2(NUM_GRP);

    typedef struct packed {
        logic             legal;
        logic             widen;
        logic             odd;
        logic             sub;
        logic             a_signed;
        logic             b_signed;
        logic [GRP_W-1:0] grp;
    } mac_ctrl_t;

endpackage

// File: rtl/vmac_decode.sv
module vmac_decode
    import vmac_pkg::*;
(
    input  logic [1:0] op_i,
    input  logic [1:0] size_i,
    input  logic [1:0] smode_i,
    output mac_ctrl_t  ctrl_o
);

    always_comb begin
        ctrl_o = '0;
        unique case (mac_op_e'(op_i))
            OP_MADD, OP_MSUB: begin
                ctrl_o.sub   = (op_i == OP_MSUB);
                ctrl_o.grp   = GRP_W'(size_i);
                ctrl_o.legal = (smode_i == SM_SS) || (smode_i == SM_UU);
            end
            OP_WEVEN, OP_WODD: begin
                ctrl_o.widen = 1'b1;
                ctrl_o.odd   = (op_i == OP_WODD);
                ctrl_o.grp   = GRP_W'(size_i) + GRP_W'(1);
                ctrl_o.legal = (smode_i != SM_BAD);
            end
        endcase
        ctrl_o.a_signed = (smode_i == SM_SS);
        ctrl_o.b_signed = (smode_i == SM_SS) || (smode_i == SM_US);
    end

    always_comb begin
        if (smode_i == 2'd3) begin
            a_r8_reserved_mode: assert (!ctrl_o.legal);
        end
        if (op_i[1]) begin
            a_r4_widen_grp: assert (ctrl_o.grp != '0);
        end
    end

endmodule

// File: rtl/vmac_lane.sv
module vmac_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o
);

    localparam int H = W / 2;

    logic [W-1:0] prod;
    assign prod = opa_i * opb_i;

    generate
        if (W > 64) begin : g_split
            // Two-word accumulate: explicit carry from low to high word.
            logic [H-1:0] p_lo, p_hi;
            logic [H:0]   lo_sum;
            logic [H-1:0] hi_sum;
            assign p_lo   = sub_i ? ~prod[H-1:0] : prod[H-1:0];
            assign p_hi   = sub_i ? ~prod[W-1:H] : prod[W-1:H];
            assign lo_sum = {1'b0, acc_i[H-1:0]} + {1'b0, p_lo} + {{H{1'b0}}, sub_i};
            assign hi_sum = acc_i[W-1:H] + p_hi + {{(H-1){1'b0}}, lo_sum[H]};
            assign res_o  = {hi_sum, lo_sum[H-1:0]};

            always_comb begin
                if (!sub_i && (res_o[H-1:0] < acc_i[H-1:0])) begin
                    a_r6_carry_into_high: assert (res_o[W-1:H] == acc_i[W-1:H] + prod[W-1:H] + H'(1));
                end
            end
        end else begin : g_flat
            assign res_o = sub_i ? (acc_i - prod) : (acc_i + prod);
        end
    endgenerate

    always_comb begin
        if (opb_i == '0) begin
            a_r2_zero_product: assert (res_o == acc_i);
        end
    end

endmodule

// File: rtl/vmac_group.sv
module vmac_group
    import vmac_pkg::*;
#(
    parameter int VEC_W    = 256,
    parameter int LANE_W   = 16,
    parameter bit HAS_SAME = 1'b1,
    parameter bit HAS_WIDE = 1'b1
) (
    input  mac_ctrl_t        ctrl_i,
    input  logic [VEC_W-1:0] acc_i,
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    output logic [VEC_W-1:0] res_o
);

    localparam int LANES  = VEC_W / LANE_W;
    localparam int NARROW = LANE_W / 2;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            logic [LANE_W-1:0] opa, opb;
            logic              lane_sub;

            if (HAS_WIDE && HAS_SAME) begin : g_both
                logic [NARROW-1:0] na, nb;
                assign na  = ctrl_i.odd ? a_i[(2*i+1)*NARROW +: NARROW] : a_i[2*i*NARROW +: NARROW];
                assign nb  = ctrl_i.odd ? b_i[(2*i+1)*NARROW +: NARROW] : b_i[2*i*NARROW +: NARROW];
                assign opa = ctrl_i.widen ? {{NARROW{ctrl_i.a_signed & na[NARROW-1]}}, na}
                                          : a_i[i*LANE_W +: LANE_W];
                assign opb = ctrl_i.widen ? {{NARROW{ctrl_i.b_signed & nb[NARROW-1]}}, nb}
                                          : b_i[i*LANE_W +: LANE_W];
                assign lane_sub = ctrl_i.sub & ~ctrl_i.widen;
            end else if (HAS_WIDE) begin : g_wide
                logic [NARROW-1:0] na, nb;
                assign na  = ctrl_i.odd ? a_i[(2*i+1)*NARROW +: NARROW] : a_i[2*i*NARROW +: NARROW];
                assign nb  = ctrl_i.odd ? b_i[(2*i+1)*NARROW +: NARROW] : b_i[2*i*NARROW +: NARROW];
                assign opa = {{NARROW{ctrl_i.a_signed & na[NARROW-1]}}, na};
                assign opb = {{NARROW{ctrl_i.b_signed & nb[NARROW-1]}}, nb};
                assign lane_sub = 1'b0;
            end else begin : g_same
                assign opa = a_i[i*LANE_W +: LANE_W];
                assign opb = b_i[i*LANE_W +: LANE_W];
                assign lane_sub = ctrl_i.sub;
            end

            vmac_lane #(.W(LANE_W)) u_lane (
                .acc_i (acc_i[i*LANE_W +: LANE_W]),
                .opa_i (opa),
                .opb_i (opb),
                .sub_i (lane_sub),
                .res_o (res_o[i*LANE_W +: LANE_W])
            );
        end
    endgenerate

endmodule

// File: rtl/vmac_unit.sv
module vmac_unit
    import vmac_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       op,
    input  logic [1:0]       elem_size,
    input  logic [1:0]       sign_mode,
    input  logic [VEC_W-1:0] acc_in,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] result,
    output logic             illegal
);

    localparam int MIN_LANE = 8;

    mac_ctrl_t        ctrl;
    logic [VEC_W-1:0] grp_res [NUM_GRP];
    logic [VEC_W-1:0] sel_res;
    stage_e           state_q, state_d;
    logic             accept;

    vmac_decode u_dec (
        .op_i    (op),
        .size_i  (elem_size),
        .smode_i (sign_mode),
        .ctrl_o  (ctrl)
    );

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            vmac_group #(
                .VEC_W    (VEC_W),
                .LANE_W   (MIN_LANE << g),
                .HAS_SAME (g < NUM_GRP - 1),
                .HAS_WIDE (g > 0)
            ) u_grp (
                .ctrl_i (ctrl),
                .acc_i  (acc_in),
                .a_i    (src_a),
                .b_i    (src_b),
                .res_o  (grp_res[g])
            );
        end
    endgenerate

    always_comb begin
        sel_res = acc_in;
        if (ctrl.legal) begin
            for (int g = 0; g < NUM_GRP; g++) begin
                if (ctrl.grp == GRP_W'(g)) sel_res = grp_res[g];
            end
        end
    end

    // Stage controller
    assign out_valid = (state_q == ST_FULL);
    assign in_ready  = !out_valid || out_ready;
    assign accept    = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;                   // LOAD
            ST_FULL:  if (out_ready && !accept) state_d = ST_EMPTY;    // DRAIN; REFILL stays FULL
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            illegal <= 1'b0;
        end else if (accept) begin
            result  <= sel_res;
            illegal <= !ctrl.legal;
        end
    end

    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(illegal)));

    a_r8_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && sign_mode == 2'd3) |=> (illegal && result == $past(acc_in)));

endmodule

// File: tb/vmac_unit_test.sv
module vmac_unit_test;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid, in_ready, out_valid, out_ready, illegal;
    logic [1:0]   op, elem_size, sign_mode;
    logic [255:0] acc_in, src_a, src_b, result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [255:0] q_res [$];
    bit           q_ill [$];
    string        q_tag [$];

    always #10 clk = ~clk;

    vmac_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op(op), .elem_size(elem_size), .sign_mode(sign_mode),
        .acc_in(acc_in), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .out_ready(out_ready),
        .result(result), .illegal(illegal)
    );

    function automatic logic [256:0] ref_calc(input int o, input int sz, input int sm,
                                               input logic [255:0] acc, input logic [255:0] a,
                                               input logic [255:0] b);
        int w, n, idx;
        bit widen, bad;
        logic [255:0] res;
        widen = (o >= 2);
        if (!widen) begin w = 8 << sz; bad = (sm >= 2); end
        else        begin w = 16 << sz; bad = (sm == 3); end
        if (bad) return {1'b1, acc};
        n = w / 2;
        res = '0;
        for (int i = 0; i < 256 / w; i++) begin
            logic [255:0] mw, mn, da, ea, eb, p, r;
            mw = (256'd1 << w) - 256'd1;
            mn = (256'd1 << n) - 256'd1;
            da = (acc >> (i * w)) & mw;
            if (!widen) begin
                ea = (a >> (i * w)) & mw;
                eb = (b >> (i * w)) & mw;
            end else begin
                idx = 2 * i + (o & 1);
                ea = (a >> (idx * n)) & mn;
                eb = (b >> (idx * n)) & mn;
                if (sm == 0 && ea[n-1]) ea = ea | ~mn;
                if (sm != 1 && eb[n-1]) eb = eb | ~mn;
            end
            p = ea * eb;
            r = (o == 1) ? (da - p) : (da + p);
            res = res | ((r & mw) << (i * w));
        end
        return {1'b0, res};
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        int pick;
        pick = int'($urandom % 5);
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        if (pick == 1) v = '1;
        if (pick == 2) v = {4{64'h8000_0000_0000_0000}};
        if (pick == 3) v = {32{8'h80}};
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle of the reference model, entered and left at a falling edge.
    task automatic step(input bit iv, input bit ordy, input int o, input int sz, input int sm,
                        input logic [255:0] acc, input logic [255:0] a, input logic [255:0] b,
                        input string tag);
        bit exp_v, acc_ok, take;
        logic [256:0] r;
        exp_v = (q_res.size() > 0);
        check(out_valid == exp_v, "R9", "out_valid", 256'(out_valid), 256'(exp_v));
        if (exp_v && out_valid) begin
            check(result == q_res[0], q_tag[0], "result", result, q_res[0]);
            check(illegal == q_ill[0], q_tag[0], "illegal", 256'(illegal), 256'(q_ill[0]));
        end
        in_valid  = iv;
        out_ready = ordy;
        op        = 2'(o);
        elem_size = 2'(sz);
        sign_mode = 2'(sm);
        acc_in    = acc;
        src_a     = a;
        src_b     = b;
        #1;
        acc_ok = !exp_v || ordy;
        check(in_ready == acc_ok, "R10", "in_ready", 256'(in_ready), 256'(acc_ok));
        take = exp_v && ordy;
        if (take) begin
            void'(q_res.pop_front());
            void'(q_ill.pop_front());
            void'(q_tag.pop_front());
        end
        if (iv && acc_ok) begin
            r = ref_calc(o, sz, sm, acc, a, b);
            q_res.push_back(r[255:0]);
            q_ill.push_back(r[256]);
            q_tag.push_back(tag);
        end
        @(negedge clk);
    endtask

    task automatic run1(input int o, input int sz, input int sm, input logic [255:0] acc,
                        input logic [255:0] a, input logic [255:0] b, input string tag);
        step(1'b1, 1'b1, o, sz, sm, acc, a, b, tag);
        step(1'b0, 1'b1, 0, 0, 0, '0, '0, '0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [255:0] acc6, a6, b6;
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        op = '0; elem_size = '0; sign_mode = '0;
        acc_in = '0; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", 256'(out_valid), 256'd0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", 256'(in_ready), 256'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 multiply-add, every lane size
        run1(0, 0, 0, {32{8'h01}}, {32{8'h80}}, {32{8'hFF}}, "R2");
        run1(0, 1, 1, rnd256(), rnd256(), rnd256(), "R2");
        run1(0, 2, 0, {8{32'hFFFF_FFFF}}, {8{32'h8000_0000}}, {8{32'h8000_0000}}, "R2");
        run1(0, 3, 0, rnd256(), rnd256(), rnd256(), "R2");
        // R3 multiply-subtract
        run1(1, 0, 0, '0, {32{8'h7F}}, {32{8'h80}}, "R3");
        run1(1, 1, 0, '0, {16{16'h7FFF}}, {16{16'h8000}}, "R3");
        run1(1, 3, 1, rnd256(), rnd256(), rnd256(), "R3");
        // R4 / R5 widening with most-negative and all-ones operands
        run1(2, 0, 0, rnd256(), {32{8'h80}}, {32{8'h80}}, "R4");
        run1(2, 2, 1, rnd256(), rnd256(), rnd256(), "R4");
        run1(3, 1, 1, '1, '1, '1, "R5");
        run1(3, 3, 0, rnd256(), rnd256(), rnd256(), "R5");
        // R7 mixed signedness: unsigned max times minus one
        run1(2, 0, 2, '0, '1, '1, "R7");
        run1(3, 2, 2, rnd256(), {8{32'h8000_0000}}, {8{32'hFFFF_FFFF}}, "R7");
        run1(2, 3, 0, '0, '1, '1, "R7");
        // R6 carry across the 64-bit word in one 128-bit half only
        acc6 = {64'h0, 64'h0, 64'h0000_0000_0000_0005, 64'hFFFF_FFFF_FFFF_FFFF};
        a6   = {64'h0, 64'h0, 64'h0, 64'h1};
        b6   = {64'h0, 64'h0, 64'h0, 64'h1};
        run1(2, 3, 1, acc6, a6, b6, "R6");
        a6 = {64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0};
        b6 = {64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0};
        run1(3, 3, 1, acc6, a6, b6, "R6");
        // R8 illegal combinations pass the accumulator through
        run1(0, 0, 3, rnd256(), rnd256(), rnd256(), "R8");
        run1(1, 2, 2, rnd256(), rnd256(), rnd256(), "R8");
        run1(3, 1, 3, rnd256(), rnd256(), rnd256(), "R8");
        // R10 backpressure: result held, new request refused
        step(1'b1, 1'b0, 0, 1, 0, rnd256(), rnd256(), rnd256(), "R10");
        step(1'b1, 1'b0, 1, 2, 0, rnd256(), rnd256(), rnd256(), "R10");
        step(1'b1, 1'b0, 2, 0, 1, rnd256(), rnd256(), rnd256(), "R10");
        step(1'b1, 1'b1, 3, 1, 2, rnd256(), rnd256(), rnd256(), "R10");
        step(1'b0, 1'b1, 0, 0, 0, '0, '0, '0, "R10");
        step(1'b0, 1'b1, 0, 0, 0, '0, '0, '0, "R10");

        // Streaming with random handshakes, all modes and sizes
        for (int n = 0; n < 800; n++) begin
            int o, sz, sm;
            string t;
            o  = int'($urandom % 4);
            sz = int'($urandom % 4);
            sm = int'($urandom % 4);
            t  = (o == 0) ? "R2" : (o == 1) ? "R3" : (o == 2) ? "R4" : "R5";
            if (sm == 3 || (o < 2 && sm == 2)) t = "R8";
            step(($urandom % 4) != 0, ($urandom % 3) != 0, o, sz, sm,
                 rnd256(), rnd256(), rnd256(), t);
        end
        step(1'b0, 1'b1, 0, 0, 0, '0, '0, '0, "R9");
        step(1'b0, 1'b1, 0, 0, 0, '0, '0, '0, "R9");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule